// File: doc/BRIEF.md
# Ripple Counter with Twisted-Ring Decoder

This block is a three-stage asynchronous binary counter whose value is also presented as a four-bit twisted-ring (Johnson-style) word. Each stage is a D flip-flop whose input is fed from its own inverted output, so the stage toggles on every active edge of its clock. Stage 0 is clocked by the input clock. Each later stage is clocked by the output of the stage below it, so a carry ripples upward through the chain and no common clock is shared.

A purely combinational decoder maps the three count bits onto the four-bit word. Each word bit is a separate function of the count. Across the eight counts the word fills with ones from the bottom and then empties from the bottom. An asynchronous active-low clear puts the chain into a known all-zero state. Without it the counter would power up in an undefined count.

The ripple outputs are only valid once every stage has finished toggling. Anything that consumes them should sample away from the falling clock edge.

Top module: `rc_ripple_johnson`

## Requirements
- R1: While `clr_ni` is 0, `count_o` and `johnson_o` are 0 with no clock edge needed, including when the clear is applied in the middle of a count.
- R2: Clock edges that arrive while `clr_ni` is 0 have no effect: the count stays 0.
- R3: Stage 0 (`count_o[0]`) toggles on every falling edge of `clk_i`, and a rising edge of `clk_i` leaves `count_o` unchanged.
- R4: Stage k toggles when stage k-1 goes from 1 to 0, so `count_o` rises by exactly one on each falling edge of `clk_i`.
- R5: After count 7 the next falling edge returns the count to 0, and the 0..7 cycle repeats.
- R6: `johnson_o`, read as an unsigned number with bit 0 first in the sequence, equals 0, 1, 3, 7, 15, 14, 12, 8 for counts 0 to 7 respectively.
- R7: `johnson_o[3]` always equals `count_o[2]`.
- R8: Between two consecutive counts, including the wrap from 7 to 0, exactly one bit of `johnson_o` changes.
- R9: After `clr_ni` returns to 1, the first falling edge of `clk_i` gives count 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Count clock; stage 0 toggles on its falling edge |
| clr_ni | input | 1 | Asynchronous clear, active low |
| count_o | output | 3 | Rippled binary count, bit 0 is the first stage |
| johnson_o | output | 4 | Decoded twisted-ring word |

## Verification
The stage flops hold the only state, so a stage that toggles on the wrong edge or misses its neighbour's fall shows up at the ports. It appears as a count step other than plus one on the very next falling edge of `clk_i`, and in the same cycle as a word that changes in zero or several bits. A decoder fault stays invisible until the count reaches the affected value, so the bench walks every count at least twice and compares each word against a value computed arithmetically. A clear that is not truly asynchronous shows as a nonzero count in the instant after `clr_ni` falls with the clock held still.

// File: rtl/rcj_pkg.sv
package rcj_pkg;
    localparam int RCJ_STAGES_DEF = 3;

    typedef struct packed {
        logic level;
    } rcj_stage_t;
endpackage

// File: rtl/rc_toggle_stage.sv
module rc_toggle_stage
    import rcj_pkg::*;
(
    input  logic clk_i,
    input  logic clr_ni,
    output logic q_o
);
    rcj_stage_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = ~st_q.level;
    end

    always_ff @(negedge clk_i or negedge clr_ni) begin
        if (!clr_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q_o = st_q.level;
endmodule

// File: rtl/rc_johnson_decode.sv
module rc_johnson_decode #(
    parameter int STAGES = rcj_pkg::RCJ_STAGES_DEF,
    localparam int LW = STAGES - 1,
    localparam int JW = 1 << LW
) (
    input  logic [STAGES-1:0] cnt_i,
    output logic [JW-1:0]     word_o
);
    logic          fill_phase_n;
    logic [LW-1:0] low_cnt;

    assign fill_phase_n = cnt_i[STAGES-1];
    assign low_cnt      = cnt_i[LW-1:0];

    for (genvar i = 0; i < JW; i++) begin : g_bit
        localparam logic [LW-1:0] IDX = LW'(i);
        logic below;
        assign below     = (low_cnt > IDX);
        assign word_o[i] = fill_phase_n ^ below;
    end
endmodule

// File: rtl/rc_ripple_johnson.sv
module rc_ripple_johnson #(
    parameter int STAGES = rcj_pkg::RCJ_STAGES_DEF,
    localparam int JW = 1 << (STAGES - 1)
) (
    input  logic              clk_i,
    input  logic              clr_ni,
    output logic [STAGES-1:0] count_o,
    output logic [JW-1:0]     johnson_o
);
    logic [STAGES-1:0] stage_q;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic stage_clk;
        if (k == 0) begin : g_first
            assign stage_clk = clk_i;
        end else begin : g_chain
            assign stage_clk = stage_q[k-1];
        end
        rc_toggle_stage u_stage (
            .clk_i (stage_clk),
            .clr_ni(clr_ni),
            .q_o   (stage_q[k])
        );
    end

    rc_johnson_decode #(.STAGES(STAGES)) u_dec (
        .cnt_i (stage_q),
        .word_o(johnson_o)
    );

    assign count_o = stage_q;
endmodule

// File: rtl/rc_ripple_johnson_chk.sv
module rc_ripple_johnson_chk #(
    parameter int STAGES = rcj_pkg::RCJ_STAGES_DEF,
    localparam int JW = 1 << (STAGES - 1)
) (
    input logic              clk_i,
    input logic              clr_ni,
    input logic [STAGES-1:0] count_o,
    input logic [JW-1:0]     johnson_o
);
    logic seen_q;

    always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) seen_q <= 1'b0;
        else         seen_q <= 1'b1;
    end

    a_r1_clear_zero: assert property (@(posedge clk_i)
        !clr_ni |-> (count_o == '0 && johnson_o == '0));

    a_r4_step_one: assert property (@(posedge clk_i) disable iff (!clr_ni)
        seen_q |-> count_o == STAGES'($past(count_o) + 1'b1));

    a_r7_msb_match: assert property (@(posedge clk_i) disable iff (!clr_ni)
        johnson_o[JW-1] == count_o[STAGES-1]);

    a_r8_one_bit: assert property (@(posedge clk_i) disable iff (!clr_ni)
        seen_q |-> $countones(johnson_o ^ $past(johnson_o)) == 1);
endmodule

bind rc_ripple_johnson rc_ripple_johnson_chk #(.STAGES(STAGES)) u_chk (
    .clk_i    (clk_i),
    .clr_ni   (clr_ni),
    .count_o  (count_o),
    .johnson_o(johnson_o)
);

// File: tb/test_rc_ripple_johnson.sv
module test_rc_ripple_johnson;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = CLK_PERIOD / 2;

    logic       clk;
    logic       clr_n;
    logic [2:0] count;
    logic [3:0] jword;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    logic [3:0] prev_word = '0;

    rc_ripple_johnson i_rc_ripple_johnson (
        .clk_i    (clk),
        .clr_ni   (clr_n),
        .count_o  (count),
        .johnson_o(jword)
    );

    function automatic logic [3:0] exp_word(input int k);
        if (k < 4) return 4'((1 << k) - 1);
        return 4'((15 << (k - 4)) & 15);
    endfunction

    task automatic check_state(input string req, input int ec);
        checks++;
        if (count !== 3'(ec) || jword !== exp_word(ec)) begin
            errors++;
            $display("FAIL %s count=%0d word=%0d expected count=%0d word=%0d",
                     req, count, jword, ec, exp_word(ec));
        end
    endtask

    task automatic fall_edge();
        clk = 1'b1;
        #HALF;
        clk = 1'b0;
        #2;
    endtask

    task automatic sweep(input int n);
        for (int s = 0; s < n; s++) begin
            prev_word = jword;
            fall_edge();
            exp_cnt = (exp_cnt + 1) % 8;
            check_state(exp_cnt == 0 ? "R5" : "R4/R6", exp_cnt);
            checks++;
            if (jword[3] !== count[2]) begin
                errors++;
                $display("FAIL R7 msb=%0b expected %0b", jword[3], count[2]);
            end
            checks++;
            if ($countones(jword ^ prev_word) != 1) begin
                errors++;
                $display("FAIL R8 changed bits=%0d expected 1", $countones(jword ^ prev_word));
            end
            #(HALF - 2);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clk = 1'b0;
        clr_n = 1'b0;
        #3;
        check_state("R1", 0);
        for (int p = 0; p < 3; p++) begin
            fall_edge();
            check_state("R2", 0);
            #(HALF - 2);
        end
        clr_n = 1'b1;
        #2;
        check_state("R1", 0);
        clk = 1'b1;
        #2;
        check_state("R3", 0);
        #(HALF - 2);
        clk = 1'b0;
        #2;
        check_state("R9", 1);
        #(HALF - 2);
        exp_cnt = 1;
        sweep(19);
        while (exp_cnt != 5) sweep(1);
        clr_n = 1'b0;
        #1;
        check_state("R1", 0);
        #2;
        clr_n = 1'b1;
        #2;
        exp_cnt = 0;
        check_state("R1", 0);
        sweep(17);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule